// File: doc/BRIEF.md
# Grouped Exception Priority Resolver

This block sits beside a processor core's exception sequencer and decides which of several simultaneous exception requests is taken next. Requests fall into three timing classes. The first holds reset, bus error and address error, and it aborts whatever is running. The second holds trace, external interrupt, illegal instruction and privilege violation, and it waits for the next instruction boundary. The third holds trap, trap-on-overflow, bounds check and zero divide, which are raised while an instruction executes. Each grant carries a one-hot code, an action code that tells the core how to act, and an internal vector number for every kind except the external interrupt. For the interrupt the vector is fetched elsewhere.

Single-cycle request pulses are latched as pending until the sequencer acknowledges the matching grant, so lower-priority requests are served in turn. The interrupt is level-sensitive and is never latched. A small state machine has three states. `S_IDLE` offers nothing. `S_OFFER` holds a grant until acknowledge. `S_CHAIN` follows the acknowledge of a trace grant while an interrupt is accepted. Its transitions are:

- IDLE→OFFER when an eligible request exists.
- OFFER→OFFER with a replaced grant when a higher first-class request preempts.
- OFFER→IDLE on acknowledge.
- OFFER→CHAIN on acknowledge of trace while the interrupt is accepted.
- CHAIN→OFFER when an eligible request exists.
- CHAIN→IDLE otherwise.

Top module: `exc_resolver`

## Requirements
- R1: While `grant_valid` is high, `grant_oh` has exactly one bit set and holds its value until `exc_ack`. After an acknowledge with nothing else eligible, `grant_valid` is low. After reset, `grant_valid` is 0, `grant_oh` is 0 and `act_code` is 0.
- R2: Bit positions in `grant_oh` follow priority, with bit 0 highest: 0 reset, 1 bus error, 2 address error, 3 trace, 4 interrupt, 5 illegal, 6 privilege, 7 trap, 8 trap-on-overflow, 9 bounds check, 10 zero divide. Among eligible requests, the lowest bit is granted.
- R3: `vec_num` takes a fixed value for each grant: reset 0, bus error 2, address error 3, illegal 4, zero divide 5, bounds check 6, trap-on-overflow 7, privilege 8, trace 9, trap 32. For these grants `vec_internal` is 1.
- R4: `act_code` is 1 (abort) for bits 0 to 2, 2 (boundary) for bits 3 to 6, and 3 (in execution) for bits 7 to 10.
- R5: Trace, illegal and privilege are granted only when `at_boundary` is high. First-class and third-class kinds are granted regardless of `at_boundary`.
- R6: An interrupt is accepted when `irq_level` > `irq_mask` or `irq_level` = 7. Its grant has `vec_internal` = 0 and `vec_num` = 0.
- R7: A request pulse stays pending until its grant is acknowledged, and then the next pending request is offered.
- R8: A first-class request of higher priority replaces an unacknowledged lower grant in the cycle after it arrives. The replaced request stays pending.
- R9: A reset request discards every other pending request.
- R10: After a trace grant is acknowledged, an accepted interrupt is granted next even while `at_boundary` is low. Without that trace, an interrupt needs `at_boundary`.
- R11: A request sampled at a clock edge while in `S_IDLE` is offered at that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_reset | input | 1 | Reset exception request pulse |
| req_bus_err | input | 1 | Bus error request pulse |
| req_addr_err | input | 1 | Address error request pulse |
| req_trace | input | 1 | Trace request pulse |
| req_illegal | input | 1 | Illegal instruction request pulse |
| req_priv | input | 1 | Privilege violation request pulse |
| req_trap | input | 1 | Trap instruction request pulse |
| req_trapv | input | 1 | Trap-on-overflow request pulse |
| req_chk | input | 1 | Bounds check request pulse |
| req_zdiv | input | 1 | Zero divide request pulse |
| irq_level | input | 3 | Current external interrupt level |
| irq_mask | input | 3 | Current interrupt priority mask |
| at_boundary | input | 1 | Core is between instructions |
| exc_ack | input | 1 | Sequencer accepts the grant |
| grant_valid | output | 1 | A grant is offered |
| grant_oh | output | 11 | One-hot granted kind |
| vec_num | output | 8 | Internal vector number |
| vec_internal | output | 1 | Vector comes from this block |
| act_code | output | 2 | 0 none, 1 abort, 2 boundary, 3 in execution |

## Verification
Every combination of the ten pulse requests, with the interrupt both present and absent, is raised in one boundary cycle and then drained grant by grant. This separates a wrong priority order, a lost pending bit and a wrong vector or action code. A sweep over all level and mask pairs separates the strict-greater comparison from the level-7 exception. Directed sequences hold `at_boundary` low to show the difference between kinds that wait for a boundary and kinds that do not. They also show preemption of an unacknowledged grant, the reset flush, and the trace-then-interrupt chain against a lone interrupt.

// File: rtl/exc_pkg.sv
package exc_pkg;
    localparam int NK      = 11;
    localparam int VEC_W   = 8;
    localparam int IX_RST  = 0;
    localparam int IX_TRC  = 3;
    localparam int IX_IRQ  = 4;
    localparam logic [NK-1:0] G0_MASK = 11'b000_0000_0111;
    localparam logic [NK-1:0] G1_MASK = 11'b000_0111_1000;
    localparam logic [NK-1:0] G2_MASK = 11'b111_1000_0000;

    typedef enum logic [1:0] {ACT_NONE, ACT_ABORT, ACT_BOUNDARY, ACT_IN_EXEC} act_e;
    typedef enum logic [1:0] {S_IDLE, S_OFFER, S_CHAIN} st_e;

    function automatic logic [VEC_W-1:0] vec_of(input int idx);
        unique case (idx)
            1:       return 8'd2;
            2:       return 8'd3;
            3:       return 8'd9;
            5:       return 8'd4;
            6:       return 8'd8;
            7:       return 8'd32;
            8:       return 8'd7;
            9:       return 8'd6;
            10:      return 8'd5;
            default: return 8'd0;
        endcase
    endfunction

    function automatic act_e act_of(input int idx);
        if (idx <= 2)      return ACT_ABORT;
        else if (idx <= 6) return ACT_BOUNDARY;
        else               return ACT_IN_EXEC;
    endfunction
endpackage

// File: rtl/exc_pick.sv
module exc_pick #(
    parameter int W = 11
) (
    input  logic [W-1:0] req_i,
    output logic [W-1:0] win_o
);
    // isolate lowest set bit: bit 0 is highest priority
    assign win_o = req_i & (~req_i + W'(1));
endmodule

// File: rtl/exc_pend.sv
module exc_pend #(
    parameter int          W    = 11,
    parameter logic [W-1:0] KEEP = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_i,
    input  logic [W-1:0] clr_i,
    input  logic         flush_i,
    output logic [W-1:0] nxt_o
);
    logic [W-1:0] q;

    for (genvar i = 0; i < W; i++) begin : g_bit
        always_comb begin
            if (flush_i) nxt_o[i] = set_i[i] & KEEP[i];
            else         nxt_o[i] = (q[i] & ~clr_i[i]) | set_i[i];
        end
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q[i] <= 1'b0;
            else        q[i] <= nxt_o[i];
        end
    end
endmodule

// File: rtl/exc_resolver.sv
module exc_resolver
    import exc_pkg::*;
#(
    parameter int LVL_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_reset,
    input  logic              req_bus_err,
    input  logic              req_addr_err,
    input  logic              req_trace,
    input  logic              req_illegal,
    input  logic              req_priv,
    input  logic              req_trap,
    input  logic              req_trapv,
    input  logic              req_chk,
    input  logic              req_zdiv,
    input  logic [LVL_W-1:0]  irq_level,
    input  logic [LVL_W-1:0]  irq_mask,
    input  logic              at_boundary,
    input  logic              exc_ack,
    output logic              grant_valid,
    output logic [NK-1:0]     grant_oh,
    output logic [VEC_W-1:0]  vec_num,
    output logic              vec_internal,
    output logic [1:0]        act_code
);
    localparam logic [LVL_W-1:0] LVL_NMI = {LVL_W{1'b1}};
    localparam logic [NK-1:0]    IRQ_BIT = NK'(1) << IX_IRQ;
    localparam logic [NK-1:0]    RST_BIT = NK'(1) << IX_RST;

    st_e           st_q, st_d;
    logic [NK-1:0] grant_q, grant_d;
    logic [NK-1:0] set_v, clr_v, pend_nxt, live, elig, cand, hp;
    logic          irq_ok, preempt;

    assign irq_ok = (irq_level == LVL_NMI) || (irq_level > irq_mask);
    assign set_v  = {req_zdiv, req_chk, req_trapv, req_trap, req_priv,
                     req_illegal, 1'b0, req_trace, req_addr_err,
                     req_bus_err, req_reset};
    assign clr_v  = (grant_valid && exc_ack) ? grant_q : '0;

    exc_pend #(.W(NK), .KEEP(RST_BIT)) u_pend (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_i   (set_v),
        .clr_i   (clr_v),
        .flush_i (req_reset),
        .nxt_o   (pend_nxt)
    );

    assign live = pend_nxt | (irq_ok ? IRQ_BIT : '0);
    assign elig = G0_MASK | G2_MASK
                | (at_boundary ? G1_MASK : '0)
                | ((st_q == S_CHAIN) ? IRQ_BIT : '0);
    assign cand = live & elig;

    exc_pick #(.W(NK)) u_pick (
        .req_i (cand),
        .win_o (hp)
    );

    assign preempt = (|(hp & G0_MASK)) && (hp < grant_q);

    // next-state process
    always_comb begin
        st_d    = st_q;
        grant_d = grant_q;
        unique case (st_q)
            S_IDLE: begin
                if (|cand) begin
                    st_d    = S_OFFER;
                    grant_d = hp;
                end
            end
            S_OFFER: begin
                if (exc_ack) begin
                    st_d    = (grant_q[IX_TRC] && irq_ok) ? S_CHAIN : S_IDLE;
                    grant_d = '0;
                end else if (preempt) begin
                    grant_d = hp;
                end
            end
            S_CHAIN: begin
                if (|cand) begin
                    st_d    = S_OFFER;
                    grant_d = hp;
                end else begin
                    st_d = S_IDLE;
                end
            end
            default: begin
                st_d    = S_IDLE;
                grant_d = '0;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q    <= S_IDLE;
            grant_q <= '0;
        end else begin
            st_q    <= st_d;
            grant_q <= grant_d;
        end
    end

    // output process
    always_comb begin
        grant_valid  = (st_q == S_OFFER);
        grant_oh     = grant_q;
        vec_num      = '0;
        vec_internal = 1'b0;
        act_code     = ACT_NONE;
        for (int i = 0; i < NK; i++) begin
            if (grant_q[i]) begin
                vec_num      = vec_of(i);
                vec_internal = (i != IX_IRQ);
                act_code     = act_of(i);
            end
        end
    end

    // R1: single grant while valid
    a_r1_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid |-> $countones(grant_oh) == 1);
    // R1: grant persists until acknowledged
    a_r1_hold: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid && !exc_ack |=> grant_valid);
    // R8: only a first-class arrival may change an unacknowledged grant
    a_r8_stable: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid && !exc_ack && !req_reset && !req_bus_err && !req_addr_err
        |=> $stable(grant_oh));
    // R5: trace, illegal and privilege start only at a boundary
    a_r5_boundary: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(grant_valid) && (grant_oh[3] || grant_oh[5] || grant_oh[6])
        |-> $past(at_boundary));
    // R6: interrupt vector is not internal
    a_r6_irq_vec: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid && grant_oh[IX_IRQ] |-> !vec_internal);
    // R9: reset request is offered next
    a_r9_reset_wins: assert property (@(posedge clk) disable iff (!rst_n)
        req_reset |=> grant_valid && grant_oh[IX_RST]);
    // R4: action code consistent with validity
    a_r4_act_none: assert property (@(posedge clk) disable iff (!rst_n)
        !grant_valid |-> act_code == 2'd0);
endmodule

// File: tb/tb_exc_resolver.sv
`timescale 1ns/1ps
module tb_exc_resolver;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [10:0] rq = '0;
    logic [2:0]  irq_level = '0, irq_mask = '0;
    logic        at_boundary = 1'b0, exc_ack = 1'b0;
    logic        grant_valid, vec_internal;
    logic [10:0] grant_oh;
    logic [7:0]  vec_num;
    logic [1:0]  act_code;
    int          n_chk = 0, n_fail = 0;
    bit          done = 1'b0;

    always #4 clk = ~clk;

    exc_resolver dut (
        .clk(clk), .rst_n(rst_n),
        .req_reset(rq[0]), .req_bus_err(rq[1]), .req_addr_err(rq[2]),
        .req_trace(rq[3]), .req_illegal(rq[5]), .req_priv(rq[6]),
        .req_trap(rq[7]), .req_trapv(rq[8]), .req_chk(rq[9]), .req_zdiv(rq[10]),
        .irq_level(irq_level), .irq_mask(irq_mask),
        .at_boundary(at_boundary), .exc_ack(exc_ack),
        .grant_valid(grant_valid), .grant_oh(grant_oh), .vec_num(vec_num),
        .vec_internal(vec_internal), .act_code(act_code)
    );

    function automatic int exp_vec(input int i);
        case (i)
            1: return 2;   2: return 3;   3: return 9;   5: return 4;
            6: return 8;   7: return 32;  8: return 7;   9: return 6;
            10: return 5;  default: return 0;
        endcase
    endfunction

    function automatic int exp_act(input int i);
        return (i <= 2) ? 1 : (i <= 6) ? 2 : 3;
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic expect_grant(input int i, input string tag);
        check(grant_valid == 1'b1, {tag, " valid"}, grant_valid, 1);
        check(grant_oh == (11'd1 << i), {tag, " grant"}, grant_oh, 1 << i);
        check(vec_num == exp_vec(i), {tag, " R3 vector"}, vec_num, exp_vec(i));
        check(vec_internal == (i != 4), {tag, " R6 internal"}, vec_internal, i != 4);
        check(act_code == exp_act(i), {tag, " R4 act"}, act_code, exp_act(i));
    endtask

    task automatic expect_idle(input string tag);
        check(grant_valid == 1'b0, tag, grant_valid, 0);
    endtask

    // drive pulses at a negedge; returns at the next negedge
    task automatic pulse(input logic [10:0] s, input bit bnd);
        rq = s & ~11'h010;
        if (s[4]) irq_level = 3'd3;
        irq_mask = 3'd0;
        at_boundary = bnd;
        @(negedge clk);
        rq = '0;
    endtask

    task automatic do_ack(input bit drop_irq);
        exc_ack = 1'b1;
        if (drop_irq) irq_level = 3'd0;
        @(negedge clk);
        exc_ack = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(grant_valid == 0, "R1 reset valid", grant_valid, 0);
        check(grant_oh == 0, "R1 reset grant", grant_oh, 0);
        check(act_code == 0, "R1 reset act", act_code, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 R7 R9 R11: every request combination drained in order
        for (int s = 0; s < 2048; s++) begin
            logic [10:0] m;
            m = s[0] ? (11'd1 | (11'(s) & 11'h010)) : 11'(s);
            pulse(11'(s), 1'b1);
            while (m != 0) begin
                int lo;
                lo = 0;
                while (!m[lo]) lo++;
                expect_grant(lo, "R2 R7 R11 sweep");
                do_ack(lo == 4);
                m[lo] = 1'b0;
            end
            expect_idle("R7 R9 drained");
        end

        // R6: level versus mask
        at_boundary = 1'b1;
        for (int lv = 0; lv < 8; lv++) begin
            for (int mk = 0; mk < 8; mk++) begin
                bit e;
                irq_level = 3'(lv);
                irq_mask  = 3'(mk);
                @(negedge clk);
                e = (lv == 7) || (lv > mk);
                check(grant_valid == e, "R6 accept", grant_valid, e);
                if (grant_valid) begin
                    check(vec_num == 0 && vec_internal == 0, "R6 vector", vec_num, 0);
                    do_ack(1'b1);
                end else begin
                    irq_level = 3'd0;
                    @(negedge clk);
                end
            end
        end
        irq_mask = 3'd0;

        // R5: boundary dependence
        pulse(11'h020, 1'b0);
        repeat (3) begin
            expect_idle("R5 illegal waits");
            @(negedge clk);
        end
        at_boundary = 1'b1;
        @(negedge clk);
        expect_grant(5, "R5 illegal at boundary");
        do_ack(1'b0);
        pulse(11'h080, 1'b0);
        expect_grant(7, "R5 trap without boundary");
        do_ack(1'b0);

        // R10: trace then interrupt chain
        pulse(11'h018, 1'b1);
        at_boundary = 1'b0;
        expect_grant(3, "R10 trace first");
        do_ack(1'b0);
        expect_grant(4, "R10 irq chained");
        do_ack(1'b1);
        expect_idle("R10 chain done");
        irq_level = 3'd3;
        repeat (2) @(negedge clk);
        expect_idle("R10 lone irq waits");
        irq_level = 3'd0;
        @(negedge clk);

        // R8: preemption of held grant
        pulse(11'h080, 1'b0);
        expect_grant(7, "R8 trap held");
        pulse(11'h002, 1'b0);
        expect_grant(1, "R8 bus error preempts");
        do_ack(1'b0);
        expect_grant(7, "R8 trap kept pending");
        do_ack(1'b0);
        expect_idle("R8 done");

        // R1: hold without ack
        pulse(11'h200, 1'b0);
        repeat (3) begin
            expect_grant(9, "R1 hold");
            @(negedge clk);
        end
        do_ack(1'b0);
        expect_idle("R1 after ack");

        // R9: reset flush
        pulse(11'h0A0, 1'b0);
        expect_grant(7, "R9 trap before reset");
        pulse(11'h001, 1'b0);
        expect_grant(0, "R9 reset wins");
        at_boundary = 1'b1;
        do_ack(1'b0);
        expect_idle("R9 flushed");
        @(negedge clk);
        expect_idle("R9 still flushed");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule